// File: doc/BRIEF.md
# Accumulator Rotate Unit

This unit carries out the four single-byte rotate instructions that act on an 8-bit processor's accumulator. There are two right rotates and two left rotates. Each direction has a circular form, where the bit that leaves one end re-enters at the other end, and a through-carry form, where the old carry flag enters and the leaving bit becomes the new carry. The caller presents an accumulator byte, a flag byte and a one-hot operation select, and strobes `validIn`. Four clocks later the unit presents the new accumulator and the new flag byte, together with a one-cycle completion pulse.

The flag rule is the same for all four operations. Sign, zero and parity/overflow pass through unchanged, and are not recomputed from the result. Half-carry, subtract and the two unused bits read as zero. The carry flag takes the bit that was rotated out. The unit captures its operands when it accepts a request, so the caller may change its inputs at once. The results stay on the outputs until the next operation completes.

Top module: `acc_rotate_unit`

## Requirements
- R1: A synchronous reset sets `accOut` and `flagOut` to 0x00 and holds `doneOut` low.
- R2: With select bit 0 (circular right), the result is the accumulator shifted down one place, with the old bit 0 placed in bit 7.
- R3: With select bit 1 (right through carry), bit 7 of the result is the carry flag (flag bit 0) as it stood when the request was accepted, and the other bits are the accumulator shifted down one place.
- R4: With select bit 2 (circular left), the result is the accumulator shifted up one place, with the old bit 7 placed in bit 0.
- R5: With select bit 3 (left through carry), bit 0 of the result is the captured carry flag, and the other bits are the accumulator shifted up one place.
- R6: The new flag byte equals (old flags AND 0xC4) OR the outgoing bit. Bits 7 (sign), 6 (zero) and 2 (parity/overflow) are kept. Bits 5, 4 (half-carry), 3 and 1 (subtract) are zero. Bit 0 is the carry, and it receives old bit 0 for right rotates and old bit 7 for left rotates.
- R7: A request is accepted when `validIn` is high at a rising edge while the unit is idle. `doneOut` is then high for exactly one cycle, starting at the fourth rising edge after that edge, and the new results appear at the same edge.
- R8: Between completions, `accOut` and `flagOut` do not change.
- R9: `validIn` is ignored while an operation is in progress, including in its completion cycle. A request may be accepted in the cycle in which `doneOut` is high.
- R10: `validIn` with a select that does not have exactly one bit set starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Request strobe |
| selIn | input | 4 | One-hot operation select: bit0 circular right, bit1 right through carry, bit2 circular left, bit3 left through carry |
| accIn | input | 8 | Accumulator operand |
| flagIn | input | 8 | Flag byte operand |
| accOut | output | 8 | Rotated accumulator |
| flagOut | output | 8 | Updated flag byte |
| doneOut | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse of one operation and the acceptance of the next request can fall in the same cycle. The sweep provokes this on every operation: it raises `validIn` for the following request during the cycle in which `doneOut` is high. It then expects that second result exactly four edges later, and expects `doneOut` to have dropped in between. A second case holds `validIn` high through the busy window with different operands. That case is judged by requiring the first operation's result, and by requiring no further completion afterwards.

// File: rtl/acc_rotate_pkg.sv
package acc_rotate_pkg;
  // operation select positions (one-hot)
  localparam int OP_COUNT   = 4;
  localparam int SEL_RCIRC  = 0;
  localparam int SEL_RCARRY = 1;
  localparam int SEL_LCIRC  = 2;
  localparam int SEL_LCARRY = 3;
  localparam logic [OP_COUNT-1:0] LEFT_MASK =
    OP_COUNT'((1 << SEL_LCIRC) | (1 << SEL_LCARRY));

  // flag byte layout
  localparam int FLAG_W     = 8;
  localparam int FLAG_SIGN  = 7;
  localparam int FLAG_ZERO  = 6;
  localparam int FLAG_PV    = 2;
  localparam int FLAG_CARRY = 0;
  localparam logic [FLAG_W-1:0] KEEP_MASK =
    FLAG_W'((1 << FLAG_SIGN) | (1 << FLAG_ZERO) | (1 << FLAG_PV));

  typedef struct packed {
    logic capture;
    logic commit;
  } ctrlStrobes_t;
endpackage

// File: rtl/acc_rotate_core.sv
module acc_rotate_core #(
  parameter int DATA_W = 8,
  parameter bit LEFT   = 1'b0
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic              carryIn,
  input  logic              useCarry,
  output logic [DATA_W-1:0] dataOut,
  output logic              bitOut
);
  logic fillBit;

  generate
    if (LEFT) begin : g_left
      assign bitOut  = dataIn[DATA_W-1];
      assign fillBit = useCarry ? carryIn : dataIn[DATA_W-1];
      assign dataOut = {dataIn[DATA_W-2:0], fillBit};
    end else begin : g_right
      assign bitOut  = dataIn[0];
      assign fillBit = useCarry ? carryIn : dataIn[0];
      assign dataOut = {fillBit, dataIn[DATA_W-1:1]};
    end
  endgenerate
endmodule

// File: rtl/acc_rotate_ctrl.sv
module acc_rotate_ctrl
  import acc_rotate_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                validIn,
  input  logic [OP_COUNT-1:0] selIn,
  output ctrlStrobes_t        strobes,
  output logic                doneOut
);
  localparam int CNT_W = $clog2(LATENCY + 1) + 1;

  logic             busy;
  logic [CNT_W-1:0] stageCnt;
  logic             selOneHot;
  logic             startReq;

  assign selOneHot = (selIn != '0) && ((selIn & (selIn - OP_COUNT'(1))) == '0);
  assign startReq  = validIn && !busy && selOneHot;

  always_comb begin
    strobes.capture = startReq;
    strobes.commit  = busy && (stageCnt == CNT_W'(LATENCY));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      stageCnt <= '0;
      doneOut  <= 1'b0;
    end else begin
      doneOut <= strobes.commit;
      if (startReq) begin
        busy     <= 1'b1;
        stageCnt <= CNT_W'(1);
      end else if (strobes.commit) begin
        busy     <= 1'b0;
        stageCnt <= '0;
      end else if (busy) begin
        stageCnt <= stageCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/acc_rotate_dp.sv
module acc_rotate_dp
  import acc_rotate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [OP_COUNT-1:0] selIn,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [FLAG_W-1:0]   flagIn,
  output logic [DATA_W-1:0]   accOut,
  output logic [FLAG_W-1:0]   flagOut
);
  logic [OP_COUNT-1:0] selHold;
  logic [DATA_W-1:0]   accHold;
  logic [FLAG_W-1:0]   flagHold;

  logic [DATA_W-1:0] rotRes [2];
  logic              rotBit [2];
  logic              useCarry [2];
  logic              goLeft;
  logic              outBit;
  logic [DATA_W-1:0] resAcc;
  logic [FLAG_W-1:0] resFlag;

  assign useCarry[0] = selHold[SEL_RCARRY];
  assign useCarry[1] = selHold[SEL_LCARRY];
  assign goLeft      = |(selHold & LEFT_MASK);

  // index 0 rotates right, index 1 rotates left
  for (genvar d = 0; d < 2; d++) begin : g_dir
    acc_rotate_core #(
      .DATA_W (DATA_W),
      .LEFT   (d == 1)
    ) u_core (
      .dataIn   (accHold),
      .carryIn  (flagHold[FLAG_CARRY]),
      .useCarry (useCarry[d]),
      .dataOut  (rotRes[d]),
      .bitOut   (rotBit[d])
    );
  end

  always_comb begin
    resAcc  = goLeft ? rotRes[1] : rotRes[0];
    outBit  = goLeft ? rotBit[1] : rotBit[0];
    resFlag = (flagHold & KEEP_MASK) | (FLAG_W'(outBit) << FLAG_CARRY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selHold  <= '0;
      accHold  <= '0;
      flagHold <= '0;
      accOut   <= '0;
      flagOut  <= '0;
    end else begin
      if (strobes.capture) begin
        selHold  <= selIn;
        accHold  <= accIn;
        flagHold <= flagIn;
      end
      if (strobes.commit) begin
        accOut  <= resAcc;
        flagOut <= resFlag;
      end
    end
  end
endmodule

// File: rtl/acc_rotate_unit.sv
module acc_rotate_unit
  import acc_rotate_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LATENCY = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                validIn,
  input  logic [OP_COUNT-1:0] selIn,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [FLAG_W-1:0]   flagIn,
  output logic [DATA_W-1:0]   accOut,
  output logic [FLAG_W-1:0]   flagOut,
  output logic                doneOut
);
  ctrlStrobes_t strobes;

  acc_rotate_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .validIn (validIn),
    .selIn   (selIn),
    .strobes (strobes),
    .doneOut (doneOut)
  );

  acc_rotate_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .selIn   (selIn),
    .accIn   (accIn),
    .flagIn  (flagIn),
    .accOut  (accOut),
    .flagOut (flagOut)
  );
endmodule

// File: rtl/acc_rotate_chk.sv
module acc_rotate_chk
  import acc_rotate_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LATENCY = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                validIn,
  input logic [OP_COUNT-1:0] selIn,
  input logic [FLAG_W-1:0]   flagIn,
  input logic [DATA_W-1:0]   accOut,
  input logic [FLAG_W-1:0]   flagOut,
  input logic                doneOut
);
  localparam int CW = $clog2(LATENCY + 1) + 1;

  logic              pend;
  logic [CW-1:0]     ccnt;
  logic [FLAG_W-1:0] capFlags;
  logic              accept;
  logic              finish;

  assign accept = validIn && $onehot(selIn) && !pend;
  assign finish = pend && (ccnt == CW'(LATENCY));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      ccnt     <= '0;
      capFlags <= '0;
    end else if (accept) begin
      pend     <= 1'b1;
      ccnt     <= CW'(1);
      capFlags <= flagIn;
    end else if (finish) begin
      pend <= 1'b0;
      ccnt <= '0;
    end else if (pend) begin
      ccnt <= ccnt + CW'(1);
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut);

  // R7
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> doneOut);

  // R9
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    doneOut |-> $past(finish));

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    doneOut |-> ((flagOut & 8'h3A) == 8'h00));

  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    doneOut |-> ((flagOut & KEEP_MASK) == (capFlags & KEEP_MASK)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !doneOut |-> ($stable(accOut) && $stable(flagOut)));
endmodule

bind acc_rotate_unit acc_rotate_chk #(
  .DATA_W  (DATA_W),
  .LATENCY (LATENCY)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .validIn (validIn),
  .selIn   (selIn),
  .flagIn  (flagIn),
  .accOut  (accOut),
  .flagOut (flagOut),
  .doneOut (doneOut)
);

// File: tb/acc_rotate_unit_bench.sv
`timescale 1ns/1ps
module acc_rotate_unit_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       validIn;
  logic [3:0] selIn;
  logic [7:0] accIn;
  logic [7:0] flagIn;
  logic [7:0] accOut;
  logic [7:0] flagOut;
  logic       doneOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  acc_rotate_unit u_acc_rotate_unit (
    .clk(clk), .rst(rst), .validIn(validIn), .selIn(selIn),
    .accIn(accIn), .flagIn(flagIn), .accOut(accOut),
    .flagOut(flagOut), .doneOut(doneOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] a, input logic [7:0] f,
                                input int op, output logic [7:0] ea,
                                output logic [7:0] ef);
    int av = a;
    int cin = f % 2;
    int outb;
    case (op)
      0: begin outb = av % 2;   ea = 8'((av / 2) + outb * 128); end
      1: begin outb = av % 2;   ea = 8'((av / 2) + cin * 128);  end
      2: begin outb = av / 128; ea = 8'((av * 2) % 256 + outb); end
      default: begin outb = av / 128; ea = 8'((av * 2) % 256 + cin); end
    endcase
    ef = (f & 8'hC4) | 8'(outb);
  endfunction

  // called at a falling edge; returns at the falling edge after doneOut rises
  task automatic runOp(input logic [7:0] a, input logic [7:0] f, input int op,
                       input string tag);
    logic [7:0] ea, ef;
    model(a, f, op, ea, ef);
    accIn = a; flagIn = f; selIn = 4'(1 << op); validIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    validIn = 1'b0; accIn = ~a; flagIn = ~f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(doneOut == 1'b0, "R7 early done", 8'(doneOut), 8'h00);
    @(posedge clk);
    @(negedge clk);
    check(doneOut == 1'b1, "R7 done", 8'(doneOut), 8'h01);
    check(accOut == ea, tag, accOut, ea);
    check(flagOut == ef, "R6 flags", flagOut, ef);
  endtask

  task automatic watchIdle(input logic [7:0] expAcc, input logic [7:0] expFlag,
                           input string tag);
    bit sawDone = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (doneOut) sawDone = 1'b1;
    end
    check(!sawDone, tag, 8'(sawDone), 8'h00);
    check(accOut == expAcc, tag, accOut, expAcc);
    check(flagOut == expFlag, tag, flagOut, expFlag);
  endtask

  initial begin
    rst = 1'b1; validIn = 1'b0; selIn = 4'b0001; accIn = 8'hA5; flagIn = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(accOut == 8'h00, "R1 acc", accOut, 8'h00);
    check(flagOut == 8'h00, "R1 flags", flagOut, 8'h00);
    check(doneOut == 1'b0, "R1 done", 8'(doneOut), 8'h00);

    // sweep: every accumulator value, both carry values, every operation,
    // issued back to back (next request raised in the done cycle)
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int c = 0; c < 2; c++) begin
          logic [7:0] f;
          f = 8'(((a * 29 + op * 53) % 256) & 8'hFE) | 8'(c);
          case (op)
            0: runOp(8'(a), f, op, "R2 circular right");
            1: runOp(8'(a), f, op, "R3 right through carry");
            2: runOp(8'(a), f, op, "R4 circular left");
            default: runOp(8'(a), f, op, "R5 left through carry");
          endcase
        end
      end
    end
    @(negedge clk);
    check(doneOut == 1'b0, "R7 single pulse", 8'(doneOut), 8'h00);

    // R9: valid held through the busy window with other operands
    accIn = 8'h96; flagIn = 8'hFF; selIn = 4'b0001; validIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    accIn = 8'h0F; flagIn = 8'h00; selIn = 4'b0100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    validIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(doneOut == 1'b1, "R9 done", 8'(doneOut), 8'h01);
    check(accOut == 8'h4B, "R9 busy ignored acc", accOut, 8'h4B);
    check(flagOut == 8'hC5 - 8'h01, "R9 busy ignored flags", flagOut, 8'hC4);
    watchIdle(8'h4B, 8'hC4, "R8 hold after R9");

    // R10: select with zero or several bits set
    accIn = 8'h01; flagIn = 8'h00; selIn = 4'b0000; validIn = 1'b1;
    @(negedge clk);
    selIn = 4'b0011;
    @(negedge clk);
    selIn = 4'b1111;
    @(negedge clk);
    validIn = 1'b0;
    watchIdle(8'h4B, 8'hC4, "R10 bad select ignored");

    // R1 reset mid-stream
    runOp(8'h81, 8'hFF, 3, "R5 before reset");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(accOut == 8'h00, "R1 acc after reset", accOut, 8'h00);
    check(flagOut == 8'h00, "R1 flags after reset", flagOut, 8'h00);
    check(doneOut == 1'b0, "R1 done after reset", 8'(doneOut), 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule